// File: doc/BRIEF.md
# Receive Interrupt Mode Logic

This block decides when a serial receiver channel asks for a receive interrupt. Assembled characters arrive on a write strobe, each with four error flags. They are held in a three-entry data queue, and a second queue holds each character's error flags alongside it. The oldest character and its flags are shown at the read port. Popping that port advances both queues at the same time. Status must therefore be read before the character is taken, because afterwards the port shows the next entry's flags.

A two-bit policy input selects one of four modes. Receive interrupts can be turned off, raised on every character, raised on special conditions only, or raised in a one-shot mode meant for DMA service. The one-shot mode reports the first character and then stays silent about later characters until software issues the re-arm command. Whatever the mode, a two-bit vector status code reports what the top entry holds.

The incoming side has no back-pressure, because a receiver cannot be stalled. A strobe that arrives while the queue is full marks an overrun instead of storing. The read side is valid/ready. `rd_valid` is high while any character is held, and a pop happens on a clock edge where both `rd_valid` and `rd_ready` are high. `rd_ready` has no effect while `rd_valid` is low.

Top module: `rxirq_top`

## Requirements
- R1: With policy 00, `irq_pending` is never high, while `vec_code` still reports the top entry.
- R2: With policy 10, `irq_pending` equals `rd_valid`.
- R3: With policy 11, `irq_pending` equals `special`.
- R4: With policy 01, a held character raises `irq_pending` until it is popped. Later characters do not raise it until `arm_next` is pulsed. `special` always raises it.
- R5: Switching the policy to 01 while a character is already held raises `irq_pending` on the next cycle.
- R6: The error flags are bit 3 overrun, bit 2 end-of-frame, bit 1 CRC/framing and bit 0 parity. `special` is high when a character is held and its bit 3, 2 or 1 is set, or its bit 0 is set while `parity_en` is high.
- R7: `vec_code` is 2'b10 when `special` is high. Otherwise it is 2'b01 when a character is held, and 2'b00 when none is.
- R8: `rd_valid` is high exactly when the queue is non-empty, whatever the policy. Characters leave in arrival order, and each pop moves `rd_data` and `rd_status` together.
- R9: The queue holds three entries. A strobe into a full queue with no pop in the same cycle discards the character and sets bit 3 of the newest stored entry. If a pop happens in the same cycle, the character is stored.
- R10: If `arm_next` and a pop happen in the same cycle under policy 01, re-arming wins and the next held character raises `irq_pending`.
- R11: After reset the queue is empty, and `rd_valid`, `irq_pending` and `vec_code` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| mode | input | 2 | Receive interrupt policy |
| parity_en | input | 1 | Counts parity errors as a special condition |
| in_valid | input | 1 | Write strobe for a received character |
| in_data | input | 8 | Received character |
| in_err | input | 4 | Error flags of the received character |
| rd_valid | output | 1 | A character is held |
| rd_ready | input | 1 | Pops the top entry when `rd_valid` is high |
| rd_data | output | 8 | Top character |
| rd_status | output | 4 | Error flags of the top character |
| arm_next | input | 1 | Re-arms the first-character interrupt |
| irq_pending | output | 1 | Receive interrupt request |
| special | output | 1 | Top entry carries a special condition |
| vec_code | output | 2 | Vector status code |

## Verification
Two pairs of functions can fall in the same clock edge. The first is a pop coinciding with a write into a full queue, which decides whether the write is stored or turned into an overrun. The second is a pop of the first character coinciding with the re-arm command. Directed sequences provoke each pair deliberately, and long random runs with frequent pops, strobes and re-arms hit them many more times. A bench-side queue model with its own arming flag predicts the outputs after every edge, and the bench compares the ports against that prediction.

// File: rtl/rxirq_pkg.sv
package rxirq_pkg;
  localparam int ERR_W   = 4;
  localparam int ERR_PAR = 0;
  localparam int ERR_CRC = 1;
  localparam int ERR_EOF = 2;
  localparam int ERR_OVR = 3;

  typedef enum logic [1:0] {
    POL_OFF   = 2'b00,
    POL_FIRST = 2'b01,
    POL_ALL   = 2'b10,
    POL_SPEC  = 2'b11
  } policy_e;

  typedef enum logic [1:0] {
    VEC_NONE = 2'b00,
    VEC_CHAR = 2'b01,
    VEC_SPEC = 2'b10
  } vec_e;
endpackage

// File: rtl/rxirq_fifo.sv
module rxirq_fifo #(
  parameter int DW    = 8,
  parameter int EW    = rxirq_pkg::ERR_W,
  parameter int DEPTH = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [DW-1:0] push_data,
  input  logic [EW-1:0] push_err,
  input  logic          pop,
  output logic [DW-1:0] top_data,
  output logic [EW-1:0] top_err,
  output logic          not_empty
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);

  logic [DW-1:0] mem_d [DEPTH];
  logic [EW-1:0] mem_e [DEPTH];
  logic [PW-1:0] rd_ptr, wr_ptr, newest;
  logic [CW-1:0] count;
  logic          full, pop_ok, store, mark_ovr;

  assign not_empty = (count != '0);
  assign full      = (count == CW'(DEPTH));
  assign pop_ok    = pop && not_empty;
  assign store     = push && (!full || pop_ok);
  assign mark_ovr  = push && full && !pop_ok;
  assign newest    = (wr_ptr == '0) ? LAST : wr_ptr - 1'b1;
  assign top_data  = mem_d[rd_ptr];
  assign top_err   = mem_e[rd_ptr];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_ptr <= '0;
      wr_ptr <= '0;
      count  <= '0;
      for (int i = 0; i < DEPTH; i++) begin
        mem_d[i] <= '0;
        mem_e[i] <= '0;
      end
    end else begin
      if (store) begin
        mem_d[wr_ptr] <= push_data;
        mem_e[wr_ptr] <= push_err;
        wr_ptr        <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
      end
      if (mark_ovr) mem_e[newest][rxirq_pkg::ERR_OVR] <= 1'b1;
      if (pop_ok) rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
      if (store && !pop_ok)      count <= count + 1'b1;
      else if (pop_ok && !store) count <= count - 1'b1;
    end
  end
endmodule

// File: rtl/rxirq_cond.sv
module rxirq_cond #(
  parameter int EW = rxirq_pkg::ERR_W
) (
  input  logic [EW-1:0] top_err,
  input  logic          not_empty,
  input  logic          parity_en,
  output logic          special,
  output logic [1:0]    vec_code
);
  import rxirq_pkg::*;
  logic [EW-1:0] mask;

  always_comb begin
    mask          = '1;
    mask[ERR_PAR] = parity_en;
  end

  assign special = not_empty && |(top_err & mask);

  always_comb begin
    if (special)        vec_code = VEC_SPEC;
    else if (not_empty) vec_code = VEC_CHAR;
    else                vec_code = VEC_NONE;
  end
endmodule

// File: rtl/rxirq_policy.sv
module rxirq_policy (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] mode,
  input  logic       arm_next,
  input  logic       pop_ok,
  input  logic       not_empty,
  input  logic       special,
  output logic       irq_pending
);
  import rxirq_pkg::*;
  logic armed;

  always_ff @(posedge clk) begin
    if (!rst_n)                     armed <= 1'b1;
    else if (mode != POL_FIRST)     armed <= 1'b1;
    else if (arm_next)              armed <= 1'b1;
    else if (pop_ok)                armed <= 1'b0;
  end

  always_comb begin
    unique case (mode)
      POL_OFF:   irq_pending = 1'b0;
      POL_FIRST: irq_pending = special || (armed && not_empty);
      POL_ALL:   irq_pending = not_empty;
      default:   irq_pending = special;
    endcase
  end
endmodule

// File: rtl/rxirq_top.sv
module rxirq_top #(
  parameter int DW    = 8,
  parameter int EW    = rxirq_pkg::ERR_W,
  parameter int DEPTH = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    mode,
  input  logic          parity_en,
  input  logic          in_valid,
  input  logic [DW-1:0] in_data,
  input  logic [EW-1:0] in_err,
  output logic          rd_valid,
  input  logic          rd_ready,
  output logic [DW-1:0] rd_data,
  output logic [EW-1:0] rd_status,
  input  logic          arm_next,
  output logic          irq_pending,
  output logic          special,
  output logic [1:0]    vec_code
);
  logic not_empty, pop_ok;

  assign rd_valid = not_empty;
  assign pop_ok   = rd_ready && not_empty;

  rxirq_fifo #(.DW(DW), .EW(EW), .DEPTH(DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_n), .push(in_valid), .push_data(in_data),
    .push_err(in_err), .pop(pop_ok), .top_data(rd_data),
    .top_err(rd_status), .not_empty(not_empty)
  );

  rxirq_cond #(.EW(EW)) u_cond (
    .top_err(rd_status), .not_empty(not_empty), .parity_en(parity_en),
    .special(special), .vec_code(vec_code)
  );

  rxirq_policy u_pol (
    .clk(clk), .rst_n(rst_n), .mode(mode), .arm_next(arm_next),
    .pop_ok(pop_ok), .not_empty(not_empty), .special(special),
    .irq_pending(irq_pending)
  );
endmodule

// File: rtl/rxirq_checker.sv
module rxirq_checker #(
  parameter int DW = 8,
  parameter int EW = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic [1:0]    mode,
  input logic          in_valid,
  input logic          rd_valid,
  input logic          rd_ready,
  input logic [DW-1:0] rd_data,
  input logic [EW-1:0] rd_status,
  input logic          irq_pending,
  input logic          special,
  input logic [1:0]    vec_code
);
  a_r1_off_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'b00) |-> !irq_pending);
  a_r2_all_tracks: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'b10) |-> (irq_pending == rd_valid));
  a_r3_spec_only: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'b11) |-> (irq_pending == special));
  a_r7_spec_code: assert property (@(posedge clk) disable iff (!rst_n)
    special |-> (vec_code == 2'b10 && rd_valid));
  a_r7_empty_code: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_valid |-> (vec_code == 2'b00));
  a_r8_top_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !rd_ready && !in_valid) |=>
      (rd_valid && $stable(rd_data) && $stable(rd_status)));
endmodule

bind rxirq_top rxirq_checker #(.DW(DW), .EW(EW)) u_chk (
  .clk(clk), .rst_n(rst_n), .mode(mode), .in_valid(in_valid),
  .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_data(rd_data),
  .rd_status(rd_status), .irq_pending(irq_pending), .special(special),
  .vec_code(vec_code)
);

// File: tb/rxirq_tb.sv
`timescale 1ns/1ps
module rxirq_top_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] mode = 2'b00;
  logic       parity_en = 1'b0;
  logic       in_valid = 1'b0;
  logic [7:0] in_data = '0;
  logic [3:0] in_err = '0;
  logic       rd_ready = 1'b0;
  logic       arm_next = 1'b0;
  logic       rd_valid, irq_pending, special;
  logic [7:0] rd_data;
  logic [3:0] rd_status;
  logic [1:0] vec_code;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [7:0] qd[$];
  logic [3:0] qe[$];
  bit armed = 1;

  always #4 clk = ~clk;

  rxirq_top dut_i (
    .clk(clk), .rst_n(rst_n), .mode(mode), .parity_en(parity_en),
    .in_valid(in_valid), .in_data(in_data), .in_err(in_err),
    .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_data(rd_data),
    .rd_status(rd_status), .arm_next(arm_next), .irq_pending(irq_pending),
    .special(special), .vec_code(vec_code)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic bit m_special();
    if (qd.size() == 0) return 0;
    return qe[0][3] | qe[0][2] | qe[0][1] | (qe[0][0] & parity_en);
  endfunction

  function automatic int m_vec();
    if (m_special()) return 2;
    if (qd.size() != 0) return 1;
    return 0;
  endfunction

  function automatic bit m_pend();
    case (mode)
      2'b00: return 0;
      2'b01: return m_special() | (armed & (qd.size() != 0));
      2'b10: return qd.size() != 0;
      default: return m_special();
    endcase
  endfunction

  function automatic string pend_tag();
    case (mode)
      2'b00: return "R1";
      2'b01: return "R4";
      2'b10: return "R2";
      default: return "R3";
    endcase
  endfunction

  task automatic check_all();
    chk("R8 valid", rd_valid, qd.size() != 0);
    if (qd.size() != 0) begin
      chk("R8 data", rd_data, qd[0]);
      chk("R9 status", rd_status, qe[0]);
    end
    chk("R6 special", special, m_special());
    chk("R7 vec", vec_code, m_vec());
    chk(pend_tag(), irq_pending, m_pend());
  endtask

  task automatic step(input bit iv, input logic [7:0] d, input logic [3:0] e,
                      input bit pop, input bit arm);
    bit pop_ok;
    in_valid = iv; in_data = d; in_err = e; rd_ready = pop; arm_next = arm;
    @(posedge clk);
    pop_ok = pop && (qd.size() != 0);
    if (mode != 2'b01) armed = 1;
    else if (arm)      armed = 1;
    else if (pop_ok)   armed = 0;
    if (iv && qd.size() == 3 && !pop_ok) begin
      logic [3:0] t;
      t = qe[2]; t[3] = 1'b1; qe[2] = t;
    end
    if (pop_ok) begin
      void'(qd.pop_front());
      void'(qe.pop_front());
    end
    if (iv && qd.size() < 3 && (qd.size() < 2 || pop_ok || qd.size() == 2)) begin
      if (!(qd.size() == 3)) begin
        qd.push_back(d);
        qe.push_back(e);
      end
    end
    @(negedge clk);
    in_valid = 0; rd_ready = 0; arm_next = 0;
    check_all();
  endtask

  task automatic drain();
    for (int i = 0; i < 4; i++) step(0, 8'h00, 4'h0, 1, 0);
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R11: reset state
    chk("R11 valid", rd_valid, 0);
    chk("R11 vec", vec_code, 0);
    chk("R11 pend", irq_pending, 0);

    // R9: fill to full, one more strobe marks overrun on newest entry
    mode = 2'b10;
    step(1, 8'hA1, 4'h0, 0, 0);
    step(1, 8'hA2, 4'h0, 0, 0);
    step(1, 8'hA3, 4'h0, 0, 0);
    step(1, 8'hA4, 4'h0, 0, 0);
    step(0, 8'h00, 4'h0, 1, 0);
    step(0, 8'h00, 4'h0, 1, 0);
    chk("R9 ovr data", rd_data, 8'hA3);
    chk("R9 ovr flag", rd_status[3], 1);
    step(0, 8'h00, 4'h0, 1, 0);
    chk("R9 dropped", rd_valid, 0);
    // R9: full plus pop stores the new character
    step(1, 8'hB1, 4'h0, 0, 0);
    step(1, 8'hB2, 4'h0, 0, 0);
    step(1, 8'hB3, 4'h0, 0, 0);
    step(1, 8'hB4, 4'h0, 1, 0);
    step(0, 8'h00, 4'h0, 1, 0);
    step(0, 8'h00, 4'h0, 1, 0);
    chk("R9 stored", rd_data, 8'hB4);
    chk("R9 no ovr", rd_status[3], 0);
    drain();

    // R6: parity gated by parity_en; R1 vector still reported when off
    mode = 2'b00; parity_en = 0;
    step(1, 8'h11, 4'h1, 0, 0);
    chk("R6 par off", special, 0);
    parity_en = 1;
    step(0, 8'h00, 4'h0, 0, 0);
    chk("R6 par on", special, 1);
    chk("R1 vec", vec_code, 2);
    chk("R1 quiet", irq_pending, 0);
    drain();

    // R5: enter first-char mode with a char already held
    mode = 2'b10;
    step(1, 8'h21, 4'h0, 0, 0);
    step(1, 8'h22, 4'h0, 0, 0);
    mode = 2'b01;
    step(0, 8'h00, 4'h0, 0, 0);
    chk("R5 entry", irq_pending, 1);
    // R4: pop first char -> silent though a char remains
    step(0, 8'h00, 4'h0, 1, 0);
    chk("R4 oneshot", irq_pending, 0);
    chk("R4 held", rd_valid, 1);
    step(0, 8'h00, 4'h0, 0, 1);
    chk("R4 rearm", irq_pending, 1);
    // R10: pop with re-arm in the same cycle
    step(1, 8'h23, 4'h0, 1, 1);
    chk("R10 pop+arm", irq_pending, 1);
    step(0, 8'h00, 4'h0, 1, 0);
    chk("R10 after", irq_pending, 0);
    step(1, 8'h24, 4'h4, 0, 0);
    chk("R4 special", irq_pending, 1);
    drain();

    // random phase
    for (int n = 0; n < 4000; n++) begin
      logic [3:0] e;
      if ($urandom % 20 == 0) mode = 2'($urandom);
      if ($urandom % 30 == 0) parity_en = 1'($urandom);
      e = ($urandom % 4 == 0) ? 4'($urandom) : 4'h0;
      step(1'($urandom % 2), 8'($urandom), e, ($urandom % 5) < 2,
           ($urandom % 10) == 0);
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule